// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Controller

This block keeps one 32-bit interrupt pending word for each of up to sixteen processors. Hardware interrupt levels 1 to 15, routed to a processor by the system-level controller, raise and drop pending bits 1 to 15 of that processor's word. Software raises and drops the soft-interrupt bits 17 to 31 through a set port and a clear port. Every other bit is out of reach of software writes.

A bus access picks the processor from a 4-bit index at address bits [15:12], so that each processor sees its registers in its own 4 KB page. It picks the register from address bits [3:2]. Register 0 reads the pending word, register 1 is the clear port and register 2 is the set port. For each processor the block works out the highest pending soft level, where pending bit j (17 to 31) stands for level j-16. It hands that level to the processor over a valid/ready pair. A level is offered only when the processor is not already holding one. It stays on the pins, unchanged, until the processor takes it with ready. The handshake has no buffering. If the level changes while one is held, the processor sees the newer value at the next offer.

Top module: `soft_irq_ctl`

## Requirements
- R1: After reset every pending word is 0, every `lvl_valid` bit is 0 and `bus_rdata` is 0.
- R2: The processor index is `bus_addr[15:12]` and the register is `bus_addr[3:2]`; other address bits are ignored. A read (`bus_rd`) of register 0 puts that processor's pending word on `bus_rdata` at the next clock edge. A read of register 1, 2 or 3 returns 0.
- R3: A write to register 1 clears every pending bit where `bus_wdata & 32'hFFFE0000` is 1. If `bus_wdata[14]` is 1, bit 31 is cleared as well. Bits 0 to 16 never change through this port.
- R4: A write to register 2 sets every pending bit where `bus_wdata & 32'hFFFE0000` is 1. Bits 0 to 16 never change through this port.
- R5: A hardware post (`hw_post`=1) with `hw_lvl`=L in 1..15 sets pending bit L of processor `hw_cpu` when `hw_on`=1 and clears it when `hw_on`=0. A post with L=0 has no effect.
- R6: The soft level of a processor is the largest j-16 over its set pending bits j in 17..31, and 0 when none is set. Hardware bits 1..15 do not contribute.
- R7: When `lvl_valid[i]` is 0 and the soft level is non-zero, the level is offered: `lvl_valid[i]` rises no later than two edges after the pending change. While `lvl_valid[i]`=1 and `lvl_ready[i]`=0, both valid and `lvl_data` slice i hold. A clock edge with `lvl_valid[i]` and `lvl_ready[i]` both 1 drops `lvl_valid[i]` for at least one cycle. An offered level is never 0.
- R8: A processor index at or above `NCPU` reads as 0, and writes and hardware posts aimed at it are ignored. They do not alias onto a lower index.
- R9: Writes to register 0 and register 3 change no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Access address: processor index [15:12], register [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| hw_post | input | 1 | Hardware level post strobe |
| hw_cpu | input | 4 | Processor that the hardware post targets |
| hw_lvl | input | 4 | Hardware level 0..15 (0 is ignored) |
| hw_on | input | 1 | 1 asserts the hardware level, 0 deasserts it |
| lvl_valid | output | NCPU | Per-processor soft level offer |
| lvl_ready | input | NCPU | Per-processor acknowledge of the offered level |
| lvl_data | output | NCPU*4 | Per-processor offered soft level, 4 bits each |

## Verification
The assertions assume that `lvl_ready` is an ordinary synchronous input that may change at any time. They also assume that `bus_rd` and `bus_wr` are never both active. The read checks further assume that each `bus_rd` pulse carries its address in the same cycle. The bench drives every strobe for exactly one cycle, from the falling edge, and never overlaps a read with a write. It holds `lvl_ready` high for the table walk and only lowers it for one processor in the hold test. Out-of-range indices 5 and 9 are picked so that they would alias onto index 1 if the decode dropped upper bits.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned SOFT_BASE = 16;
  localparam int unsigned ALIAS_BIT = 14;
  localparam int unsigned TOP_BIT   = 31;
  localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_CLR  = 2'd1,
    REG_SET  = 2'd2,
    REG_RSV  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sic_addr_dec.sv
module sic_addr_dec
  import sic_pkg::*;
#(
  parameter int unsigned NCPU    = 4,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IDX_LSB = 12,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NCPU-1:0]   cpu_hit,
  output logic              do_clr,
  output logic              do_set,
  output logic              do_rd
);
  logic [IDX_W-1:0] idx;
  reg_sel_e         word;
  logic             in_range;
  logic             unused_addr;

  assign idx         = bus_addr[IDX_LSB +: IDX_W];
  assign word        = reg_sel_e'(bus_addr[3:2]);
  assign unused_addr = ^bus_addr;

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      cpu_hit[i] = (idx == IDX_W'(i));
    end
  end

  assign in_range = |cpu_hit;
  assign do_clr   = bus_wr && in_range && (word == REG_CLR);
  assign do_set   = bus_wr && in_range && (word == REG_SET);
  assign do_rd    = bus_rd && in_range && (word == REG_PEND);
endmodule

// File: rtl/sic_pend_reg.sv
module sic_pend_reg
  import sic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              hw_hit,
  input  logic              hw_on,
  input  logic [LVL_W-1:0]  hw_lvl,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] pend_d
);
  logic [WORD_W-1:0] clr_mask;
  logic [WORD_W-1:0] set_mask;
  logic [WORD_W-1:0] hw_bit;

  always_comb begin
    clr_mask = wdata & SOFT_MASK;
    if (wdata[ALIAS_BIT]) clr_mask[TOP_BIT] = 1'b1;
    set_mask = wdata & SOFT_MASK;
    hw_bit   = WORD_W'(1) << hw_lvl;
  end

  always_comb begin
    pend_d = pend_q;
    if (sel && clr_en) pend_d = pend_d & ~clr_mask;
    if (sel && set_en) pend_d = pend_d | set_mask;
    if (hw_hit) begin
      if (hw_on) pend_d = pend_d | hw_bit;
      else       pend_d = pend_d & ~hw_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/sic_prio.sv
module sic_prio
  import sic_pkg::*;
(
  input  logic [WORD_W-1:0] pend,
  output logic [LVL_W-1:0]  level
);
  always_comb begin
    level = '0;
    for (int j = SOFT_BASE + 1; j < WORD_W; j++) begin
      if (pend[j]) level = LVL_W'(j - SOFT_BASE);
    end
  end
endmodule

// File: rtl/sic_lvl_port.sv
module sic_lvl_port
  import sic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_d,
  input  logic             ready,
  output logic             valid,
  output logic [LVL_W-1:0] data
);
  logic [LVL_W-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      cur_q <= lvl_d;
      if (valid) begin
        if (ready) valid <= 1'b0;
      end else if (cur_q != '0) begin
        valid <= 1'b1;
        data  <= cur_q;
      end
    end
  end
endmodule

// File: rtl/soft_irq_ctl.sv
module soft_irq_ctl
  import sic_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CPU_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic                  hw_post,
  input  logic [CPU_W-1:0]      hw_cpu,
  input  logic [LVL_W-1:0]      hw_lvl,
  input  logic                  hw_on,
  output logic [NCPU-1:0]       lvl_valid,
  input  logic [NCPU-1:0]       lvl_ready,
  output logic [NCPU*LVL_W-1:0] lvl_data
);
  logic [NCPU-1:0]   cpu_hit;
  logic              do_clr;
  logic              do_set;
  logic              do_rd;
  logic [WORD_W-1:0] pend_q [NCPU];
  logic [WORD_W-1:0] pend_d [NCPU];
  logic [LVL_W-1:0]  soft_lvl [NCPU];
  logic [WORD_W-1:0] rd_word;

  sic_addr_dec #(
    .NCPU    (NCPU),
    .ADDR_W  (ADDR_W),
    .IDX_LSB (12),
    .IDX_W   (CPU_W)
  ) u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .cpu_hit  (cpu_hit),
    .do_clr   (do_clr),
    .do_set   (do_set),
    .do_rd    (do_rd)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic hw_hit;
    assign hw_hit = hw_post && (hw_cpu == CPU_W'(g)) && (hw_lvl != '0);

    sic_pend_reg u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (cpu_hit[g]),
      .clr_en (do_clr),
      .set_en (do_set),
      .wdata  (bus_wdata),
      .hw_hit (hw_hit),
      .hw_on  (hw_on),
      .hw_lvl (hw_lvl),
      .pend_q (pend_q[g]),
      .pend_d (pend_d[g])
    );

    sic_prio u_prio (
      .pend  (pend_d[g]),
      .level (soft_lvl[g])
    );

    sic_lvl_port u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_d (soft_lvl[g]),
      .ready (lvl_ready[g]),
      .valid (lvl_valid[g]),
      .data  (lvl_data[g*LVL_W +: LVL_W])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (cpu_hit[i]) rd_word = rd_word | pend_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= do_rd ? rd_word : '0;
  end
endmodule

// File: rtl/sic_chk.sv
module sic_chk
  import sic_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [WORD_W-1:0]     bus_rdata,
  input logic [NCPU-1:0]       lvl_valid,
  input logic [NCPU-1:0]       lvl_ready,
  input logic [NCPU*LVL_W-1:0] lvl_data
);
  logic idx_oor;
  assign idx_oor = (32'(bus_addr[15:12]) >= NCPU);

  AST_RD_OTHER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] != 2'd0) |=> (bus_rdata == '0)); // R2

  AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx_oor) |=> (bus_rdata == '0)); // R8

  AST_RD_NO_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata[0] == 1'b0)); // R5

  AST_RD_NO_BIT16: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata[16] == 1'b0)); // R4

  for (genvar g = 0; g < NCPU; g++) begin : g_lane
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_valid[g] && !lvl_ready[g]) |=>
        (lvl_valid[g] && $stable(lvl_data[g*LVL_W +: LVL_W]))); // R7

    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_valid[g] && lvl_ready[g]) |=> !lvl_valid[g]); // R7

    AST_NO_ZERO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_valid[g] |-> (lvl_data[g*LVL_W +: LVL_W] != '0)); // R6
  end
endmodule

bind soft_irq_ctl sic_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .lvl_valid (lvl_valid),
  .lvl_ready (lvl_ready),
  .lvl_data  (lvl_data)
);

// File: tb/sim_soft_irq_ctl.sv
`timescale 1ns/1ps
module sim_soft_irq_ctl;
  localparam int NC = 4;
  localparam int NV = 38;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          hw_post = 1'b0;
  logic [3:0]    hw_cpu = '0;
  logic [3:0]    hw_lvl = '0;
  logic          hw_on = 1'b0;
  logic [NC-1:0] lvl_valid;
  logic [NC-1:0] lvl_ready = '1;
  logic [NC*4-1:0] lvl_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  soft_irq_ctl #(.NCPU(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_post(hw_post), .hw_cpu(hw_cpu), .hw_lvl(hw_lvl), .hw_on(hw_on),
    .lvl_valid(lvl_valid), .lvl_ready(lvl_ready), .lvl_data(lvl_data)
  );

  // op: 0 write, 1 read-compare, 2 level-compare, 3 hardware post
  // fields: {op[1:0], req[3:0], addr[15:0], data[31:0], expect[31:0]}
  localparam logic [85:0] VEC [NV] = '{
    {2'd1, 4'd1, 16'h0000, 32'h0,        32'h0},        // R1
    {2'd0, 4'd4, 16'h0008, 32'h80020000, 32'h0},
    {2'd1, 4'd4, 16'h0000, 32'h0,        32'h80020000}, // R4
    {2'd2, 4'd6, 16'h0000, 32'h0,        32'd15},       // R6
    {2'd0, 4'd3, 16'h0004, 32'h80000000, 32'h0},
    {2'd1, 4'd3, 16'h0000, 32'h0,        32'h00020000}, // R3
    {2'd2, 4'd6, 16'h0000, 32'h0,        32'd1},        // R6
    {2'd0, 4'd4, 16'h1008, 32'h0001FFFF, 32'h0},
    {2'd1, 4'd4, 16'h1000, 32'h0,        32'h0},        // R4 low bits masked
    {2'd3, 4'd5, 16'h1000, 32'h15,       32'h0},
    {2'd1, 4'd5, 16'h1000, 32'h0,        32'h20},       // R5
    {2'd2, 4'd6, 16'h1000, 32'h0,        32'd0},        // R6 hw bits excluded
    {2'd0, 4'd4, 16'h1008, 32'h00100000, 32'h0},
    {2'd1, 4'd4, 16'h1000, 32'h0,        32'h00100020},
    {2'd2, 4'd6, 16'h1000, 32'h0,        32'd4},        // R6
    {2'd0, 4'd3, 16'h1004, 32'h00000020, 32'h0},
    {2'd1, 4'd3, 16'h1000, 32'h0,        32'h00100020}, // R3 low bits kept
    {2'd3, 4'd5, 16'h1000, 32'h05,       32'h0},
    {2'd1, 4'd5, 16'h1000, 32'h0,        32'h00100000}, // R5 deassert
    {2'd0, 4'd3, 16'h2008, 32'h80000000, 32'h0},
    {2'd0, 4'd3, 16'h2004, 32'h00004000, 32'h0},
    {2'd1, 4'd3, 16'h2000, 32'h0,        32'h0},        // R3 bit 14 alias
    {2'd1, 4'd2, 16'h1004, 32'h0,        32'h0},        // R2
    {2'd1, 4'd2, 16'h100C, 32'h0,        32'h0},        // R2
    {2'd0, 4'd8, 16'h5008, 32'hFFFE0000, 32'h0},
    {2'd1, 4'd8, 16'h5000, 32'h0,        32'h0},        // R8
    {2'd1, 4'd8, 16'h1000, 32'h0,        32'h00100000}, // R8 no alias
    {2'd3, 4'd8, 16'h9000, 32'h13,       32'h0},
    {2'd1, 4'd8, 16'h1000, 32'h0,        32'h00100000}, // R8 hw post
    {2'd0, 4'd9, 16'h3000, 32'hFFFE0000, 32'h0},
    {2'd0, 4'd9, 16'h300C, 32'hFFFE0000, 32'h0},
    {2'd1, 4'd9, 16'h3000, 32'h0,        32'h0},        // R9
    {2'd3, 4'd5, 16'h3000, 32'h10,       32'h0},
    {2'd1, 4'd5, 16'h3000, 32'h0,        32'h0},        // R5 level 0
    {2'd0, 4'd2, 16'h3FF8, 32'h00040000, 32'h0},
    {2'd1, 4'd2, 16'h3000, 32'h0,        32'h00040000}, // R2 ignored bits
    {2'd2, 4'd6, 16'h3000, 32'h0,        32'd2},        // R6
    {2'd2, 4'd7, 16'h2000, 32'h0,        32'd0}         // R7 no offer at 0
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_post(input logic [3:0] c, input logic on, input logic [3:0] l);
    hw_post = 1'b1; hw_cpu = c; hw_on = on; hw_lvl = l;
    @(negedge clk);
    hw_post = 1'b0;
  endtask

  task automatic get_level(input int c, output logic [3:0] got);
    bit seen = 0;
    got = '0;
    repeat (4) begin
      @(negedge clk);
      if (!seen && lvl_valid[c]) begin
        seen = 1;
        got = lvl_data[c*4 +: 4];
      end
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [3:0]  lv;
    repeat (2) @(negedge clk);
    check(1, 32'(lvl_valid), 32'h0);   // R1
    check(1, bus_rdata, 32'h0);         // R1
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      int          rq;
      logic [15:0] a;
      logic [31:0] d, e;
      op = VEC[v][85:84];
      rq = int'(VEC[v][83:80]);
      a  = VEC[v][79:64];
      d  = VEC[v][63:32];
      e  = VEC[v][31:0];
      case (op)
        2'd0: do_write(a, d);
        2'd1: begin do_read(a, rd); check(rq, rd, e); end
        2'd2: begin get_level(int'(a[13:12]), lv); check(rq, 32'(lv), e); end
        default: do_post(a[15:12], d[4], d[3:0]);
      endcase
    end

    // R7: hold the offer of cpu0 while the processor is busy
    lvl_ready[0] = 1'b0;
    repeat (3) @(negedge clk);
    check(7, {31'h0, lvl_valid[0]}, 32'h1);
    check(7, 32'(lvl_data[3:0]), 32'd1);
    do_write(16'h0008, 32'h02000000);
    repeat (2) @(negedge clk);
    check(7, {31'h0, lvl_valid[0]}, 32'h1);
    check(7, 32'(lvl_data[3:0]), 32'd1);          // R7 held despite new level
    do_read(16'h0000, rd);
    check(4, rd, 32'h02020000);
    lvl_ready[0] = 1'b1;
    @(negedge clk);
    lvl_ready[0] = 1'b0;
    check(7, {31'h0, lvl_valid[0]}, 32'h0);      // R7 dropped after ack
    @(negedge clk);
    check(7, {31'h0, lvl_valid[0]}, 32'h1);
    check(7, 32'(lvl_data[3:0]), 32'd9);          // R7 newer level offered
    lvl_ready[0] = 1'b1;

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1, 32'(lvl_valid), 32'h0);
    check(1, bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'h0000, rd);
    check(1, rd, 32'h0);
    do_read(16'h1000, rd);
    check(1, rd, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule